// File: doc/BRIEF.md
# UART Receive Word Packer

This block is the receive half of a serial port. It turns a standard asynchronous line into characters and packs them four at a time into 32-bit words. The words go into a small word FIFO that a host drains. The host starts a transfer by writing the number of characters it expects. The transfer then ends in one of two ways: the expected number of characters has arrived, or the line has stayed quiet for a programmed number of character times after some data came in. In both cases any partly filled word is written to the FIFO with its unused upper bytes cleared to zero. The number of characters taken during that transfer is held in a snapshot output, so the host knows how many bytes of the last word are real.

The host also sees whether the FIFO holds data, whether its level is above a watermark, and whether characters were lost because the FIFO was full. A receive-reset command discards everything buffered. An error-reset command clears the loss flag.

Top module: `uart_rx_packer`

## Requirements
- R1: The line idles high. A frame is one low start bit, eight data bits sent LSB first, then one stop bit. Each bit lasts CLKS_PER_BIT clock cycles, and each data bit is sampled in the middle of its bit period.
- R2: A pulse on arm_i loads arm_len_i, starts a transfer, zeroes the character count and clears done_o. When the count of accepted characters reaches the loaded length, the transfer ends and done_o goes high.
- R3: A character that completes while no transfer is active is thrown away. It reaches neither the FIFO nor the count.
- R4: While stale events are enabled, a transfer is active and at least one character has been accepted, a quiet line for stale_timeout_i full character times (10*CLKS_PER_BIT cycles each) ends the transfer. The timer restarts with every character. The event sets stale_o and done_o. stale_o stays high until stale_clr_i. stale_en_i enables stale events; nothing else enables them.
- R5: When a transfer ends, snap_cnt_o takes the number of characters accepted in that transfer. It holds that value until the next transfer ends.
- R6: Within a FIFO word the earliest character sits in bits [7:0] and the next ones in [15:8], [23:16] and [31:24]. A word written when a transfer ends with fewer than four characters has zeros in its unused upper bytes.
- R7: rx_lev_o is high exactly when the number of words in the FIFO is greater than rx_wm_i.
- R8: rx_ready_o is high when the FIFO holds at least one word. rd_data_o shows the oldest word, and rd_en_i removes it.
- R9: A character that completes during a transfer while the FIFO is full is discarded and sets overrun_o. Only reset_err_i clears overrun_o; reset_rx_i does not.
- R10: reset_rx_i empties the FIFO, throws away the partly packed word, ends any active transfer and disables stale events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line |
| arm_i | input | 1 | Pulse that starts a transfer |
| arm_len_i | input | LEN_W | Transfer length in characters |
| stale_en_i | input | 1 | Pulse that enables stale events |
| stale_clr_i | input | 1 | Pulse that clears stale_o |
| reset_rx_i | input | 1 | Receive-reset command pulse |
| reset_err_i | input | 1 | Error-reset command pulse |
| stale_timeout_i | input | TO_W | Quiet time before a stale event, in character times |
| rx_wm_i | input | LVL_W | FIFO level watermark in words |
| rd_en_i | input | 1 | Pops the oldest FIFO word |
| rd_data_o | output | 32 | Oldest FIFO word |
| rx_ready_o | output | 1 | FIFO not empty |
| overrun_o | output | 1 | A character was lost to a full FIFO |
| snap_cnt_o | output | LEN_W | Characters accepted in the last finished transfer |
| stale_o | output | 1 | Stale event flag |
| done_o | output | 1 | The transfer has ended |
| rx_lev_o | output | 1 | FIFO level above the watermark |

## Verification
Each character completes at the middle of its stop bit, about two sync cycles plus 9.5 bit times after the start edge. The word write, the count, the snapshot and done_o appear one clock after that. The bench sends whole frames and samples a few cycles after each frame ends, on the falling edge. Command pulses take effect on the next rising edge, so their results are checked at the following falling edge. A stale event is due about stale_timeout_i character times after the last stop-bit sample. The bench therefore checks that it is still absent one character time after the frame, and present several character times later.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RXS_IDLE,
    RXS_START,
    RXS_DATA,
    RXS_STOP
  } rxs_e;

  localparam int unsigned BITS_PER_FRAME = 10;
  localparam int unsigned CHAR_W = 8;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic              busy_o,
  output logic              vld_o,
  output logic [CHAR_W-1:0] data_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

  logic [1:0]        sync_q;
  rxs_e              st_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        bit_q;
  logic [CHAR_W-1:0] sh_q;
  logic              rx_s;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RXS_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= 1'b0;
      unique case (st_q)
        RXS_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) st_q <= RXS_START;
        end
        RXS_START: begin
          if (cnt_q == HALF) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= rx_s ? RXS_IDLE : RXS_DATA;  // glitch rejects
          end else cnt_q <= cnt_q + 1'b1;
        end
        RXS_DATA: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            sh_q  <= {rx_s, sh_q[CHAR_W-1:1]};
            if (bit_q == 3'd7) st_q <= RXS_STOP;
            else               bit_q <= bit_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RXS_STOP: begin
          if (cnt_q == LAST) begin
            vld_o  <= 1'b1;
            data_o <= sh_q;
            st_q   <= RXS_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= RXS_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != RXS_IDLE);
endmodule

// File: rtl/rx_stale_timer.sv
module rx_stale_timer #(
  parameter int unsigned CHAR_CLKS = 80,
  parameter int unsigned TO_W      = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            fire_o
);
  localparam int unsigned TW = $clog2(CHAR_CLKS + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(CHAR_CLKS - 1);

  logic [TW-1:0]   tick_q;
  logic [TO_W-1:0] chr_q;
  logic            wrap;

  assign wrap   = (tick_q == TICK_LAST);
  assign fire_o = run_i && !restart_i && wrap &&
                  ({1'b0, chr_q} + 1'b1 >= {1'b0, timeout_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      chr_q  <= '0;
    end else if (!run_i || restart_i || fire_o) begin
      tick_q <= '0;
      chr_q  <= '0;
    end else if (wrap) begin
      tick_q <= '0;
      chr_q  <= chr_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [LW-1:0]     level_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [LW-1:0]     lvl_q;
  logic              do_wr, do_rd;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign level_o = lvl_q;
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_wr) wp_q <= nxt(wp_q);
      if (do_rd) rp_q <= nxt(rp_q);
      if (do_wr && !do_rd)      lvl_q <= lvl_q + 1'b1;
      else if (do_rd && !do_wr) lvl_q <= lvl_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[g] <= '0;
      else if (do_wr && wp_q == PW'(g))    mem_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/uart_rx_packer.sv
module uart_rx_packer
  import uart_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 8,
  parameter int unsigned FIFO_DEPTH   = 4,
  parameter int unsigned LEN_W        = 12,
  parameter int unsigned TO_W         = 4,
  localparam int unsigned WORD_W      = 32,
  localparam int unsigned LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              arm_i,
  input  logic [LEN_W-1:0]  arm_len_i,
  input  logic              stale_en_i,
  input  logic              stale_clr_i,
  input  logic              reset_rx_i,
  input  logic              reset_err_i,
  input  logic [TO_W-1:0]   stale_timeout_i,
  input  logic [LVL_W-1:0]  rx_wm_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rx_ready_o,
  output logic              overrun_o,
  output logic [LEN_W-1:0]  snap_cnt_o,
  output logic              stale_o,
  output logic              done_o,
  output logic              rx_lev_o
);
  localparam int unsigned LANES     = WORD_W / CHAR_W;
  localparam int unsigned LANE_W    = $clog2(LANES);
  localparam int unsigned CHAR_CLKS = BITS_PER_FRAME * CLKS_PER_BIT;

  logic              ch_vld, rx_busy;
  logic [CHAR_W-1:0] ch_data;
  logic              active_q, stale_en_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [LANE_W-1:0] lane_q;
  logic [CHAR_W-1:0] byte_q [LANES];
  logic [WORD_W-1:0] wdata;
  logic              fifo_full, fifo_empty;
  logic [LVL_W-1:0]  fifo_lvl;
  logic              accept, lost, len_end, stale_end, xfer_end;
  logic              push, stale_run;

  uart_rx_deser #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .busy_o (rx_busy),
    .vld_o  (ch_vld),
    .data_o (ch_data)
  );

  assign stale_run = stale_en_q && active_q && (cnt_q != '0) && !reset_rx_i;

  rx_stale_timer #(.CHAR_CLKS(CHAR_CLKS), .TO_W(TO_W)) u_stale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (stale_run),
    .restart_i (ch_vld || rx_busy),
    .timeout_i (stale_timeout_i),
    .fire_o    (stale_end)
  );

  assign accept   = ch_vld && active_q && !fifo_full && !reset_rx_i;
  assign lost     = ch_vld && active_q && fifo_full && !reset_rx_i;
  assign len_end  = accept && (cnt_q + 1'b1 == len_q);
  assign xfer_end = len_end || stale_end;
  // partial lanes imply a non-full FIFO, so a stale flush always fits
  assign push     = (accept && (lane_q == LANE_W'(LANES - 1) || len_end)) ||
                    (stale_end && lane_q != '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata[g*CHAR_W +: CHAR_W] =
      (accept && lane_q == LANE_W'(g)) ? ch_data : byte_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               byte_q[g] <= '0;
      else if (reset_rx_i || push || stale_end)  byte_q[g] <= '0;
      else if (accept && lane_q == LANE_W'(g))   byte_q[g] <= ch_data;
    end
  end

  rx_word_fifo #(.DEPTH(FIFO_DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (reset_rx_i),
    .wr_i    (push),
    .wdata_i (wdata),
    .rd_i    (rd_en_i),
    .rdata_o (rd_data_o),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .level_o (fifo_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      stale_en_q <= 1'b0;
      len_q      <= '0;
      cnt_q      <= '0;
      lane_q     <= '0;
      snap_cnt_o <= '0;
      stale_o    <= 1'b0;
      done_o     <= 1'b0;
    end else if (reset_rx_i) begin
      active_q   <= 1'b0;
      stale_en_q <= 1'b0;
      cnt_q      <= '0;
      lane_q     <= '0;
      if (stale_clr_i) stale_o <= 1'b0;
    end else begin
      if (stale_en_i)  stale_en_q <= 1'b1;
      if (stale_clr_i) stale_o    <= 1'b0;
      if (arm_i) begin
        active_q <= 1'b1;
        len_q    <= arm_len_i;
        cnt_q    <= '0;
        done_o   <= 1'b0;
      end else if (xfer_end) begin
        active_q   <= 1'b0;
        done_o     <= 1'b1;
        lane_q     <= '0;
        snap_cnt_o <= len_end ? cnt_q + 1'b1 : cnt_q;
        if (stale_end) stale_o <= 1'b1;
      end else if (accept) begin
        cnt_q  <= cnt_q + 1'b1;
        lane_q <= lane_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          overrun_o <= 1'b0;
    else if (reset_err_i) overrun_o <= 1'b0;
    else if (lost)        overrun_o <= 1'b1;
  end

  assign rx_ready_o = !fifo_empty;
  assign rx_lev_o   = (fifo_lvl > rx_wm_i);
endmodule

// File: rtl/uart_rx_packer_chk.sv
module uart_rx_packer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reset_rx_i,
  input logic        reset_err_i,
  input logic        rd_en_i,
  input logic [31:0] rd_data_o,
  input logic        rx_ready_o,
  input logic        overrun_o,
  input logic        stale_o,
  input logic        done_o,
  input logic        rx_lev_o,
  input logic        fifo_full
);
  // R8
  head_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o && !rd_en_i && !reset_rx_i |=> $stable(rd_data_o));
  // R9
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !reset_err_i |=> overrun_o);
  // R9
  overrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(fifo_full));
  // R4
  stale_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stale_o) |-> done_o);
  // R10
  rx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_rx_i |=> !rx_ready_o);
  // R7
  level_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_lev_o |-> rx_ready_o);
endmodule

bind uart_rx_packer uart_rx_packer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reset_rx_i  (reset_rx_i),
  .reset_err_i (reset_err_i),
  .rd_en_i     (rd_en_i),
  .rd_data_o   (rd_data_o),
  .rx_ready_o  (rx_ready_o),
  .overrun_o   (overrun_o),
  .stale_o     (stale_o),
  .done_o      (done_o),
  .rx_lev_o    (rx_lev_o),
  .fifo_full   (fifo_full)
);

// File: tb/tb_uart_rx_packer.sv
module tb_uart_rx_packer;
  localparam int CPB   = 8;
  localparam int CHARC = 10 * CPB;
  localparam int LEN_W = 12;
  localparam int TO_W  = 4;
  localparam int LVL_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, arm = 1'b0, sten = 1'b0, stclr = 1'b0, rrx = 1'b0, rerr = 1'b0, rd = 1'b0;
  logic [LEN_W-1:0] arm_len = '0;
  logic [TO_W-1:0]  sto = 4'd2;
  logic [LVL_W-1:0] wm = 3'd3;
  logic [31:0] rdata;
  logic rdy, ovr, stale, done, lev;
  logic [LEN_W-1:0] snap;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_rx_packer #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(4), .LEN_W(LEN_W), .TO_W(TO_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .arm_i(arm), .arm_len_i(arm_len),
    .stale_en_i(sten), .stale_clr_i(stclr), .reset_rx_i(rrx), .reset_err_i(rerr),
    .stale_timeout_i(sto), .rx_wm_i(wm), .rd_en_i(rd), .rd_data_o(rdata),
    .rx_ready_o(rdy), .overrun_o(ovr), .snap_cnt_o(snap), .stale_o(stale),
    .done_o(done), .rx_lev_o(lev)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx = 1'b0;
    wait_cyc(CPB);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      wait_cyc(CPB);
    end
    rx = 1'b1;
    wait_cyc(CPB);
  endtask

  task automatic arm_len_go(input int n);
    arm_len = LEN_W'(n);
    pulse(arm);
  endtask

  task automatic pop(input string req, input logic [31:0] exp);
    @(negedge clk);
    chk({req, " ready"}, 32'(rdy), 32'd1);
    chk({req, " word"}, rdata, exp);
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset;
    wait_cyc(1);
    chk("R8 reset ready", 32'(rdy), 0);
    chk("R9 reset overrun", 32'(ovr), 0);
    chk("R5 reset snap", 32'(snap), 0);
    chk("R4 reset stale", 32'(stale), 0);
    chk("R2 reset done", 32'(done), 0);
    chk("R7 reset level", 32'(lev), 0);
  endtask

  task automatic t_length_end;
    arm_len_go(6);
    chk("R2 done clears on arm", 32'(done), 0);
    for (int i = 0; i < 6; i++) send(8'h11 + 8'(i));
    wait_cyc(4);
    chk("R2 done on length", 32'(done), 1);
    chk("R5 snap length", 32'(snap), 6);
    chk("R4 no stale on length end", 32'(stale), 0);
    pop("R1 R6 full word", 32'h14131211);
    pop("R6 padded word", 32'h00001615);
    chk("R8 drained", 32'(rdy), 0);
  endtask

  task automatic t_idle_drop;
    send(8'h77);
    wait_cyc(4);
    chk("R3 idle char dropped", 32'(rdy), 0);
    chk("R5 snap held", 32'(snap), 6);
  endtask

  task automatic t_stale;
    sto = 4'd2;
    pulse(sten);
    arm_len_go(100);
    for (int i = 0; i < 5; i++) send(8'h21 + 8'(i));
    wait_cyc(CHARC);
    chk("R4 not stale early", 32'(stale), 0);
    chk("R8 first word ready", 32'(rdy), 1);
    wait_cyc(4 * CHARC);
    chk("R4 stale fired", 32'(stale), 1);
    chk("R4 done on stale", 32'(done), 1);
    chk("R5 snap stale", 32'(snap), 5);
    pop("R1 stale word0", 32'h24232221);
    pop("R6 stale partial", 32'h00000025);
    pulse(stclr);
    chk("R4 stale cleared", 32'(stale), 0);
  endtask

  task automatic t_rx_reset;
    pulse(rrx);
    arm_len_go(100);
    send(8'hA1); send(8'hA2);
    wait_cyc(5 * CHARC);
    chk("R10 stale disabled after rx reset", 32'(stale), 0);
    chk("R4 partial held without stale", 32'(rdy), 0);
    pulse(rrx);
    arm_len_go(2);
    send(8'h31); send(8'h32);
    wait_cyc(4);
    chk("R2 done short", 32'(done), 1);
    pop("R10 packing cleared", 32'h00003231);
  endtask

  task automatic t_level;
    wm = 3'd1;
    arm_len_go(8);
    for (int i = 0; i < 4; i++) send(8'h60 + 8'(i));
    wait_cyc(4);
    chk("R7 one word not above wm", 32'(lev), 0);
    for (int i = 4; i < 8; i++) send(8'h60 + 8'(i));
    wait_cyc(4);
    chk("R7 two words above wm", 32'(lev), 1);
    pop("R8 lev word0", 32'h63626160);
    chk("R7 back to one", 32'(lev), 0);
    pop("R8 lev word1", 32'h67666564);
  endtask

  task automatic t_overrun;
    arm_len_go(20);
    for (int i = 0; i < 16; i++) send(8'h40 + 8'(i));
    wait_cyc(4);
    chk("R9 no overrun when just full", 32'(ovr), 0);
    send(8'h50);
    wait_cyc(4);
    chk("R9 overrun set", 32'(ovr), 1);
    pop("R9 w0", 32'h43424140);
    pop("R9 w1", 32'h47464544);
    pop("R9 w2", 32'h4B4A4948);
    pop("R9 w3", 32'h4F4E4D4C);
    chk("R9 lost char not stored", 32'(rdy), 0);
    chk("R9 overrun sticky", 32'(ovr), 1);
    pulse(rrx);
    chk("R9 rx reset keeps overrun", 32'(ovr), 1);
    pulse(rerr);
    chk("R9 error reset clears", 32'(ovr), 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_length_end();
    t_idle_drop();
    t_stale();
    t_rx_reset();
    t_level();
    t_overrun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule